// File: doc/BRIEF.md
# Minimum-Hold Time-Slot Bus Arbiter

This block shares one address/data bus between a storage-interface requester and a set of other requesters. Each requester has a request input and a grant output, and at most one grant is high at a time. When the storage requester wins the bus, a slot timer is loaded from a 16-bit slot-length register. Until that timer runs out, the storage requester cannot be taken off the bus. The register counts peripheral-bus clock cycles.

Once the slot has run out, the storage requester keeps the bus for as long as no other request is pending. As soon as another request is pending, the arbiter pauses the storage requester. A change of owner always leaves the bus idle for exactly one cycle. The other requesters are served in round-robin order. Storage and the others alternate whenever both sides are waiting.

Top module: `slot_arb`

## Requirements
- R1: After reset, every grant is low and the slot-length register reads 128.
- R2: A write stores the written value in the slot-length register, except that 0xFFFF is stored as 0xFFFE. The new value can be read on the cycle after the write.
- R3: At most one grant output is high in any cycle.
- R4: While it keeps requesting, the storage requester keeps its grant for at least L cycles, where L is the slot length (a value of 0 counts as 1). If another request is pending when the slot ends, the grant is high for exactly L cycles.
- R5: After the slot has expired, and while no other request is pending, the storage grant stays high. The storage grant drops on the cycle after another request is first sampled.
- R6: If the storage requester drops its request, its grant goes low on the next cycle, even if the slot has not expired.
- R7: Between two owners there is exactly one cycle with no grant. Whenever the bus is idle and a request is pending, a grant follows on the next cycle.
- R8: The slot timer is loaded from the register each time the storage requester is newly granted. A write during a storage grant does not change the current slot. It takes effect at the next grant.
- R9: The other requesters are granted in round-robin order. The next one chosen is the first requesting index after the last one granted, wrapping from N_OTHER-1 back to 0.
- R10: When the bus is idle, a pending storage request wins unless the storage requester was the last owner and another request is pending.
- R11: A granted other requester keeps its grant for as long as its request stays high, even while the storage requester is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral-bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_wr_en | input | 1 | Write strobe for the slot-length register |
| slot_wr_data | input | 16 | Value to write into the slot-length register |
| slot_len | output | 16 | Current slot-length register value |
| stor_req | input | 1 | Storage-interface bus request |
| stor_gnt | output | 1 | Storage-interface bus grant |
| oth_req | input | N_OTHER | Requests from the other requesters |
| oth_gnt | output | N_OTHER | Grants to the other requesters |

## Verification
The bench sweeps slot lengths from 1 to 12 with a competing request held from the start, and counts storage grant cycles against L. An off-by-one in the slot timer would show up as L-1 or L+1 cycles. A design that skips the gap would grant in the same cycle the old owner leaves. It also writes to the register during a live slot, and a design that reloads from the live register would cut that slot short. The remaining corners are these. A long expired slot must be paused only once a competing request appears. An early release must hand over at once and not wait for the timer. Rotation must wrap from the top index to index 0. The 0xFFFF clamp must hold while 0xFFFE and ordinary values pass through unchanged.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int SLOT_W = 16;
  localparam logic [SLOT_W-1:0] SLOT_MAX = {{(SLOT_W-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_STOR = 2'd1,
    OWN_OTH  = 2'd2
  } owner_e;

  // Highest legal slot value is all-ones minus one; the all-ones code maps there.
  function automatic logic [SLOT_W-1:0] clamp_slot(input logic [SLOT_W-1:0] v);
    return (v == {SLOT_W{1'b1}}) ? SLOT_MAX : v;
  endfunction

  // Slot is over when at most one guaranteed cycle is left (0 behaves as 1).
  function automatic logic slot_over(input logic [SLOT_W-1:0] left);
    return left <= SLOT_W'(1);
  endfunction
endpackage

// File: rtl/slot_len_reg.sv
module slot_len_reg
  import slot_arb_pkg::*;
#(
  parameter logic [SLOT_W-1:0] RESET_SLOT = SLOT_W'(128)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_data,
  output logic [SLOT_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= RESET_SLOT;
    else if (wr_en) value <= clamp_slot(wr_data);
  end
endmodule

// File: rtl/slot_timer.sv
module slot_timer
  import slot_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] load_val,
  input  logic              run,
  output logic              expired
);
  logic [SLOT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left <= '0;
    else if (load) left <= load_val;
    else if (run && left != '0) left <= left - SLOT_W'(1);
  end

  assign expired = slot_over(left);
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N     = 3,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last_idx,
  output logic             any,
  output logic [IDX_W-1:0] pick_idx
);
  // Walk offsets from farthest to nearest so the nearest requester after last wins.
  always_comb begin
    any      = 1'b0;
    pick_idx = '0;
    for (int k = N; k >= 1; k--) begin
      int idx;
      idx = (int'(last_idx) + k) % N;
      if (req[idx]) begin
        any      = 1'b1;
        pick_idx = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/slot_arb.sv
module slot_arb
  import slot_arb_pkg::*;
#(
  parameter int                N_OTHER    = 3,
  parameter logic [SLOT_W-1:0] RESET_SLOT = SLOT_W'(128),
  localparam int               IDX_W      = (N_OTHER > 1) ? $clog2(N_OTHER) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_wr_en,
  input  logic [SLOT_W-1:0]  slot_wr_data,
  output logic [SLOT_W-1:0]  slot_len,
  input  logic               stor_req,
  output logic               stor_gnt,
  input  logic [N_OTHER-1:0] oth_req,
  output logic [N_OTHER-1:0] oth_gnt
);
  owner_e           owner;
  logic [IDX_W-1:0] cur_oth;
  logic [IDX_W-1:0] last_oth;
  logic             last_was_stor;

  // Named internal events.
  logic             any_oth;
  logic [IDX_W-1:0] pick_idx;
  logic             slot_expired;
  logic             pick_stor;
  logic             enter_stor;
  logic             enter_oth;
  logic             stor_release;
  logic             preempt;
  logic             oth_release;

  slot_len_reg #(.RESET_SLOT(RESET_SLOT)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (slot_wr_en),
    .wr_data (slot_wr_data),
    .value   (slot_len)
  );

  rr_pick #(.N(N_OTHER), .IDX_W(IDX_W)) u_rr (
    .req      (oth_req),
    .last_idx (last_oth),
    .any      (any_oth),
    .pick_idx (pick_idx)
  );

  slot_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (enter_stor),
    .load_val (slot_len),
    .run      (owner == OWN_STOR),
    .expired  (slot_expired)
  );

  assign pick_stor    = stor_req && !(last_was_stor && any_oth);
  assign enter_stor   = (owner == OWN_NONE) && pick_stor;
  assign enter_oth    = (owner == OWN_NONE) && !pick_stor && any_oth;
  assign stor_release = (owner == OWN_STOR) && !stor_req;
  assign preempt      = (owner == OWN_STOR) && stor_req && slot_expired && any_oth;
  assign oth_release  = (owner == OWN_OTH) && !oth_req[cur_oth];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner         <= OWN_NONE;
      cur_oth       <= '0;
      last_oth      <= IDX_W'(N_OTHER - 1);
      last_was_stor <= 1'b0;
    end else begin
      unique case (owner)
        OWN_NONE: begin
          if (enter_stor) begin
            owner         <= OWN_STOR;
            last_was_stor <= 1'b1;
          end else if (enter_oth) begin
            owner         <= OWN_OTH;
            cur_oth       <= pick_idx;
            last_oth      <= pick_idx;
            last_was_stor <= 1'b0;
          end
        end
        OWN_STOR: if (stor_release || preempt) owner <= OWN_NONE;
        OWN_OTH:  if (oth_release) owner <= OWN_NONE;
        default:  owner <= OWN_NONE;
      endcase
    end
  end

  assign stor_gnt = (owner == OWN_STOR);

  always_comb begin
    oth_gnt = '0;
    if (owner == OWN_OTH) oth_gnt[cur_oth] = 1'b1;
  end
endmodule

// File: rtl/slot_arb_chk.sv
module slot_arb_chk
  import slot_arb_pkg::*;
#(
  parameter int N_OTHER = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               slot_wr_en,
  input logic [SLOT_W-1:0]  slot_wr_data,
  input logic [SLOT_W-1:0]  slot_len,
  input logic               stor_req,
  input logic               stor_gnt,
  input logic [N_OTHER-1:0] oth_req,
  input logic [N_OTHER-1:0] oth_gnt,
  input logic               slot_expired
);
  logic [N_OTHER:0] gv;
  assign gv = {stor_gnt, oth_gnt};

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gv));

  // R2
  clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(slot_wr_en) && $past(slot_wr_data) == {SLOT_W{1'b1}} |-> slot_len == SLOT_MAX);

  // R4
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stor_gnt) && $past(stor_req) |-> $past(slot_expired));

  // R5
  no_idle_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stor_gnt) && $past(stor_req) |-> $past(|oth_req));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stor_gnt && !stor_req |=> !stor_gnt);

  // R7
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gv != '0) && ($past(gv) != '0) |-> gv == $past(gv));

  // R7
  work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gv == '0) && (stor_req || (|oth_req)) |=> gv != '0);

  // R11
  oth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oth_gnt != '0) && ((oth_gnt & oth_req) != '0) |=> oth_gnt == $past(oth_gnt));
endmodule

bind slot_arb slot_arb_chk #(.N_OTHER(N_OTHER)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slot_wr_en   (slot_wr_en),
  .slot_wr_data (slot_wr_data),
  .slot_len     (slot_len),
  .stor_req     (stor_req),
  .stor_gnt     (stor_gnt),
  .oth_req      (oth_req),
  .oth_gnt      (oth_gnt),
  .slot_expired (slot_expired)
);

// File: tb/slot_arb_test.sv
`timescale 1ns/1ps
module slot_arb_test;
  localparam int NO = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot_wr_en = 1'b0;
  logic [15:0]   slot_wr_data = '0;
  logic [15:0]   slot_len;
  logic          stor_req = 1'b0;
  logic          stor_gnt;
  logic [NO-1:0] oth_req = '0;
  logic [NO-1:0] oth_gnt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  slot_arb #(.N_OTHER(NO)) uut (
    .clk(clk), .rst_n(rst_n), .slot_wr_en(slot_wr_en), .slot_wr_data(slot_wr_data),
    .slot_len(slot_len), .stor_req(stor_req), .stor_gnt(stor_gnt),
    .oth_req(oth_req), .oth_gnt(oth_gnt)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<150000 cycles", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one edge and sample at the falling edge; R3 is checked every cycle.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk($countones({stor_gnt, oth_gnt}) <= 1, "R3 one grant", $countones({stor_gnt, oth_gnt}), 1);
  endtask

  task automatic write_slot(input logic [15:0] v);
    slot_wr_en = 1'b1; slot_wr_data = v;
    step();
    slot_wr_en = 1'b0;
  endtask

  function automatic int oth_index(input logic [NO-1:0] g);
    for (int i = 0; i < NO; i++) if (g[i]) return i;
    return -1;
  endfunction

  // Count storage grant cycles starting at a granted cycle.
  task automatic count_stor(output int n);
    n = 0;
    while (stor_gnt) begin
      n++;
      step();
    end
  endtask

  task automatic idle_all();
    stor_req = 1'b0; oth_req = '0;
    step(); step();
  endtask

  initial begin
    int n;
    int cur;
    int nxt;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(slot_len == 16'd128, "R1 slot reset", slot_len, 128);
    chk(!stor_gnt && oth_gnt == '0, "R1 grants idle", {stor_gnt, oth_gnt}, 0);
    rst_n = 1'b1;
    step();

    // R2 clamp and pass-through
    write_slot(16'hFFFF);
    chk(slot_len == 16'hFFFE, "R2 clamp", slot_len, 16'hFFFE);
    write_slot(16'hFFFE);
    chk(slot_len == 16'hFFFE, "R2 max kept", slot_len, 16'hFFFE);
    write_slot(16'h1234);
    chk(slot_len == 16'h1234, "R2 plain", slot_len, 16'h1234);

    // R4 / R7 sweep of slot lengths with a competitor pending from the start
    for (int L = 1; L <= 12; L++) begin
      write_slot(16'(L));
      stor_req = 1'b1; oth_req = 3'b001;
      step();
      chk(stor_gnt, "R10 storage first", stor_gnt, 1);
      count_stor(n);
      chk(n == L, "R4 slot length", n, L);
      chk(oth_gnt == '0, "R7 idle gap", oth_gnt, 0);
      step();
      chk(oth_gnt == 3'b001, "R7 handover", oth_gnt, 1);
      idle_all();
    end

    // R8 write during a live slot
    write_slot(16'd5);
    stor_req = 1'b1; oth_req = 3'b001;
    step();
    slot_wr_en = 1'b1; slot_wr_data = 16'd2;
    n = 0;
    while (stor_gnt) begin
      n++;
      step();
      slot_wr_en = 1'b0;
    end
    chk(n == 5, "R8 live slot unchanged", n, 5);
    step();
    chk(oth_gnt == 3'b001, "R7 handover after R8", oth_gnt, 1);
    oth_req = '0;
    step();
    oth_req = 3'b001;
    step();
    chk(stor_gnt, "R10 storage after other", stor_gnt, 1);
    count_stor(n);
    chk(n == 2, "R8 reload on new grant", n, 2);
    idle_all();

    // R5 expired slot held while nobody else waits
    write_slot(16'd3);
    stor_req = 1'b1;
    step();
    for (int k = 0; k < 10; k++) step();
    chk(stor_gnt, "R5 held past slot", stor_gnt, 1);
    oth_req = 3'b010;
    step();
    chk(!stor_gnt, "R5 paused on new request", stor_gnt, 0);
    step();
    chk(oth_gnt == 3'b010, "R5 handover", oth_gnt, 2);
    idle_all();

    // R6 early release
    write_slot(16'd50);
    stor_req = 1'b1; oth_req = 3'b100;
    step();
    chk(stor_gnt, "R6 storage granted", stor_gnt, 1);
    step(); step(); step();
    stor_req = 1'b0;
    step();
    chk(!stor_gnt && oth_gnt == '0, "R6 release immediate", {stor_gnt, oth_gnt}, 0);
    step();
    chk(oth_gnt == 3'b100, "R7 handover after release", oth_gnt, 4);
    idle_all();

    // R9 rotation wrapping from index 2, R11 hold under storage pressure
    oth_req = 3'b111;
    step();
    cur = oth_index(oth_gnt);
    chk(cur == 0, "R9 wrap to 0", cur, 0);
    stor_req = 1'b1;
    for (int k = 0; k < 20; k++) step();
    chk(oth_gnt == 3'b001, "R11 other holds", oth_gnt, 1);
    stor_req = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      oth_req[cur] = 1'b0;
      step();
      chk(oth_gnt == '0 && !stor_gnt, "R7 gap in rotation", oth_gnt, 0);
      oth_req[cur] = 1'b1;
      step();
      nxt = (cur + 1) % NO;
      chk(oth_index(oth_gnt) == nxt, "R9 round robin", oth_index(oth_gnt), nxt);
      cur = nxt;
    end

    // R10 storage wins after an other owner; then full slot and rotation continues
    stor_req = 1'b1;
    oth_req[cur] = 1'b0;
    step();
    oth_req[cur] = 1'b1;
    step();
    chk(stor_gnt, "R10 storage wins idle", stor_gnt, 1);
    count_stor(n);
    chk(n == 50, "R4 long slot", n, 50);
    step();
    nxt = (cur + 1) % NO;
    chk(oth_index(oth_gnt) == nxt, "R9 rotation after storage", oth_index(oth_gnt), nxt);
    idle_all();
    chk(!stor_gnt && oth_gnt == '0, "R7 idle when no request", {stor_gnt, oth_gnt}, 0);

    report();
  end
endmodule